// File: doc/BRIEF.md
# Software-Filled Translation Buffer with Lockable Slots

This block is a fully associative address translation cache whose contents are written only by software. A processor register port first stages a tag word and a data word. A load command then commits both words into the slot named by a replacement pointer. A lock base keeps that pointer away from the low slots. Those slots are reserved for translations that must never be replaced.

A lookup port takes a 32-bit virtual address. One cycle later it returns a hit flag, the physical address and the page attributes. Each slot carries its own page size (4KB, 64KB, 1MB or 16MB), and the size sets how many upper address bits take part in the match. Software can remove a single slot by naming its tag and size, or it can sweep the whole buffer. A sweep spares slots marked as preserved. While translation is on, a miss records the faulting address and raises a maskable interrupt.

Top module: `sw_tlb`

## Requirements
- R1: After reset every slot is invalid, every readable register reads 0, `irq` is low and `lk_rsp_valid` is low. A lookup with translation enabled then misses.
- R2: Writing a value with bit 0 set to the load register (0x10) copies the staged tag word (0x08) and data word (0x0C) into the slot named by the replacement pointer. The pointer then advances by one; from the last slot it returns to the lock base.
- R3: In the lock register (0x04), bits [4:0] hold the replacement pointer and bits [12:8] hold the lock base. A write that puts the pointer below the base sets the pointer to the base.
- R4: The tag word carries the virtual tag in [31:12], the valid bit in bit 2, the preserved bit in bit 3 and the size code in [1:0] (0=1MB, 1=64KB, 2=4KB, 3=16MB). A valid slot hits when the address matches its tag in [31:12], [31:16], [31:20] or [31:24] for 4KB, 64KB, 1MB or 16MB. The physical address takes the bits above that boundary from the slot and the bits below it from the virtual address.
- R5: On a hit, `lk_endian`, `lk_elem_sz` and `lk_mixed` return bit 9, bits [8:7] and bit 6 of the slot's data word. The data word's [31:12] holds the physical page.
- R6: When several slots hit, the lowest-numbered slot supplies the result.
- R7: Writing a value with bit 0 set to the single-flush register (0x14) invalidates every valid slot whose size equals the staged size and whose tag matches the staged tag over that size's bits, including preserved slots. Slots with another size are untouched.
- R8: Any write to the sweep register (0x60) invalidates, in one cycle, every slot not marked preserved and leaves preserved slots valid.
- R9: A lookup that misses while translation is enabled (control register 0x00 bit 0) stores its address in the fault register (0x20) and sets status bit 0 (0x18), visible with the response.
- R10: `irq` is high exactly when status bit 0 and enable bit 0 (0x1C) are both set. Writing 1 to status bit 0 clears it, unless a miss sets it in the same cycle.
- R11: With translation disabled, every lookup returns a hit with the physical address equal to the virtual address and zero attributes. It does not touch the status or fault registers.
- R12: The table base register (0x24) reads back the written value with bits [6:0] cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_rsp_valid | output | 1 | Response valid, one cycle after the request |
| lk_hit | output | 1 | Translation found (or translation disabled) |
| lk_paddr | output | 32 | Physical address |
| lk_endian | output | 1 | Page endianness attribute |
| lk_elem_sz | output | 2 | Page element size attribute |
| lk_mixed | output | 1 | Page mixed-size attribute |
| irq | output | 1 | Miss interrupt |

## Verification
The assertions assume that only one register is written per cycle, so a load, a single flush and a sweep never land on the same edge. The bench keeps to this by issuing each register access as a separate one-cycle write. The assertions also assume that lookups only sample a settled address; the bench changes `lk_vaddr` only on falling edges. The sweep over all 32 slots uses disjoint top-byte regions, one per slot. As a result, a hit or a miss is always predicted from a single slot, except in the deliberate overlap that tests priority.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;

  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] A_CTRL   = 8'h00;
  localparam logic [REG_AW-1:0] A_LOCK   = 8'h04;
  localparam logic [REG_AW-1:0] A_TAG    = 8'h08;
  localparam logic [REG_AW-1:0] A_DATA   = 8'h0C;
  localparam logic [REG_AW-1:0] A_LOAD   = 8'h10;
  localparam logic [REG_AW-1:0] A_FLUSH1 = 8'h14;
  localparam logic [REG_AW-1:0] A_ISTAT  = 8'h18;
  localparam logic [REG_AW-1:0] A_IEN    = 8'h1C;
  localparam logic [REG_AW-1:0] A_FAULT  = 8'h20;
  localparam logic [REG_AW-1:0] A_TTB    = 8'h24;
  localparam logic [REG_AW-1:0] A_SWEEP  = 8'h60;

  localparam int LOCK_BASE_LSB = 8;

  typedef enum logic [1:0] {
    PG_1M  = 2'd0,
    PG_64K = 2'd1,
    PG_4K  = 2'd2,
    PG_16M = 2'd3
  } pgsz_e;

  // full slot contents, as held in the store
  typedef struct packed {
    logic        vld;
    logic        keep;
    pgsz_e       sz;
    logic [19:0] vtag;
    logic [19:0] ptag;
    logic        endn;
    logic [1:0]  esz;
    logic        mix;
  } slot_t;

  // fields the lookup path needs
  typedef struct packed {
    logic        vld;
    pgsz_e       sz;
    logic [19:0] vtag;
    logic [19:0] ptag;
    logic        endn;
    logic [1:0]  esz;
    logic        mix;
  } look_t;

  // significant tag bits for a page size
  function automatic logic [19:0] tag_mask(pgsz_e sz);
    case (sz)
      PG_4K:   return 20'hFFFFF;
      PG_64K:  return 20'hFFFF0;
      PG_1M:   return 20'hFFF00;
      default: return 20'hFF000;
    endcase
  endfunction

endpackage

// File: rtl/sw_tlb_ctrl.sv
module sw_tlb_ctrl
  import sw_tlb_pkg::*;
#(
  parameter  int ENTRIES = 32,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              miss_i,
  input  logic [31:0]       miss_addr_i,
  output logic              xlat_en_o,
  output slot_t             stg_o,
  output logic [IDX_W-1:0]  victim_o,
  output logic              load_o,
  output logic              flush1_o,
  output logic              sweep_o,
  output logic              irq_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             en_q,    en_n;
  logic [IDX_W-1:0] base_q,  base_n;
  logic [IDX_W-1:0] vic_q,   vic_n;
  logic [31:0]      tag_q,   tag_n;
  logic [31:0]      dat_q,   dat_n;
  logic             ien_q,   ien_n;
  logic             stat_q,  stat_n;
  logic [31:0]      fault_q, fault_n;
  logic [31:0]      ttb_q,   ttb_n;
  logic [IDX_W-1:0] wr_base, wr_vic;

  function automatic logic hit_addr(logic [REG_AW-1:0] a);
    return reg_wr_i && (reg_addr_i == a);
  endfunction

  assign load_o   = hit_addr(A_LOAD)   && reg_wdata_i[0];
  assign flush1_o = hit_addr(A_FLUSH1) && reg_wdata_i[0];
  assign sweep_o  = hit_addr(A_SWEEP);

  // next state
  always_comb begin
    en_n    = en_q;
    base_n  = base_q;
    vic_n   = vic_q;
    tag_n   = tag_q;
    dat_n   = dat_q;
    ien_n   = ien_q;
    stat_n  = stat_q;
    fault_n = fault_q;
    ttb_n   = ttb_q;
    wr_base = reg_wdata_i[LOCK_BASE_LSB +: IDX_W];
    wr_vic  = reg_wdata_i[IDX_W-1:0];
    if (wr_base > LAST) wr_base = LAST;
    if (wr_vic  > LAST) wr_vic  = LAST;
    if (wr_vic < wr_base) wr_vic = wr_base;

    if (hit_addr(A_CTRL)) en_n  = reg_wdata_i[0];
    if (hit_addr(A_TAG))  tag_n = reg_wdata_i;
    if (hit_addr(A_DATA)) dat_n = reg_wdata_i;
    if (hit_addr(A_IEN))  ien_n = reg_wdata_i[0];
    if (hit_addr(A_TTB))  ttb_n = {reg_wdata_i[31:7], 7'd0};

    if (hit_addr(A_LOCK)) begin
      base_n = wr_base;
      vic_n  = wr_vic;
    end else if (load_o) begin
      vic_n = (vic_q == LAST) ? base_q : vic_q + 1'b1;
    end

    if (hit_addr(A_ISTAT) && reg_wdata_i[0]) stat_n = 1'b0;
    if (miss_i) begin
      stat_n  = 1'b1;
      fault_n = miss_addr_i;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      base_q  <= '0;
      vic_q   <= '0;
      tag_q   <= '0;
      dat_q   <= '0;
      ien_q   <= 1'b0;
      stat_q  <= 1'b0;
      fault_q <= '0;
      ttb_q   <= '0;
    end else begin
      en_q    <= en_n;
      base_q  <= base_n;
      vic_q   <= vic_n;
      tag_q   <= tag_n;
      dat_q   <= dat_n;
      ien_q   <= ien_n;
      stat_q  <= stat_n;
      fault_q <= fault_n;
      ttb_q   <= ttb_n;
    end
  end

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o[0] = en_q;
      A_LOCK: begin
        reg_rdata_o[IDX_W-1:0]                = vic_q;
        reg_rdata_o[LOCK_BASE_LSB +: IDX_W]   = base_q;
      end
      A_TAG:   reg_rdata_o = tag_q;
      A_DATA:  reg_rdata_o = dat_q;
      A_ISTAT: reg_rdata_o[0] = stat_q;
      A_IEN:   reg_rdata_o[0] = ien_q;
      A_FAULT: reg_rdata_o = fault_q;
      A_TTB:   reg_rdata_o = ttb_q;
      default: reg_rdata_o = '0;
    endcase
  end

  always_comb begin
    stg_o.vld  = tag_q[2];
    stg_o.keep = tag_q[3];
    stg_o.sz   = pgsz_e'(tag_q[1:0]);
    stg_o.vtag = tag_q[31:12];
    stg_o.ptag = dat_q[31:12];
    stg_o.endn = dat_q[9];
    stg_o.esz  = dat_q[8:7];
    stg_o.mix  = dat_q[6];
  end

  assign xlat_en_o = en_q;
  assign victim_o  = vic_q;
  assign irq_o     = stat_q & ien_q;

  // R3
  victim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_q >= base_q) && (vic_q <= LAST));

  // R9
  miss_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_i |=> stat_q && (fault_q == $past(miss_addr_i)));

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_addr(A_ISTAT) && reg_wdata_i[0] && !miss_i) |=> !stat_q);

endmodule

// File: rtl/sw_tlb_store.sv
module sw_tlb_store
  import sw_tlb_pkg::*;
#(
  parameter  int ENTRIES = 32,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [IDX_W-1:0]         victim_i,
  input  slot_t                    stg_i,
  input  logic                     flush1_i,
  input  logic                     sweep_i,
  output look_t [ENTRIES-1:0]      look_o
);

  logic [ENTRIES-1:0] vld_v;
  logic [ENTRIES-1:0] keep_v;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    slot_t cur_q, cur_n;
    logic  tgt_match;

    assign tgt_match = cur_q.vld && (cur_q.sz == stg_i.sz) &&
                       (((cur_q.vtag ^ stg_i.vtag) & tag_mask(cur_q.sz)) == 20'd0);

    always_comb begin
      cur_n = cur_q;
      if (load_i && (victim_i == IDX_W'(g))) cur_n = stg_i;
      if (flush1_i && tgt_match)             cur_n.vld = 1'b0;
      if (sweep_i && !cur_q.keep)            cur_n.vld = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= '0;
      else        cur_q <= cur_n;
    end

    assign vld_v[g]  = cur_q.vld;
    assign keep_v[g] = cur_q.keep;

    always_comb begin
      look_o[g].vld  = cur_q.vld;
      look_o[g].sz   = cur_q.sz;
      look_o[g].vtag = cur_q.vtag;
      look_o[g].ptag = cur_q.ptag;
      look_o[g].endn = cur_q.endn;
      look_o[g].esz  = cur_q.esz;
      look_o[g].mix  = cur_q.mix;
    end
  end

  // R2
  load_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (vld_v[$past(victim_i)] == $past(stg_i.vld)));

  // R8
  sweep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_i |=> ((vld_v & ~keep_v) == '0));

  // R8
  sweep_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_i |=> ((vld_v & keep_v) == $past(vld_v & keep_v)));

endmodule

// File: rtl/sw_tlb_match.sv
module sw_tlb_match
  import sw_tlb_pkg::*;
#(
  parameter  int ENTRIES = 32,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic [31:0]         vaddr_i,
  input  logic                xlat_en_i,
  input  look_t [ENTRIES-1:0] look_i,
  output logic                miss_o,
  output logic                rsp_valid_o,
  output logic                rsp_hit_o,
  output logic [31:0]         rsp_paddr_o,
  output logic                rsp_endn_o,
  output logic [1:0]          rsp_esz_o,
  output logic                rsp_mix_o
);

  logic [ENTRIES-1:0] hit_v;
  logic [IDX_W-1:0]   idx;
  logic               any;
  look_t              win;
  logic [31:0]        low_m;
  logic [31:0]        pa;

  logic        val_q,  val_n;
  logic        hit_q,  hit_n;
  logic [31:0] pa_q,   pa_n;
  logic        endn_q, endn_n;
  logic [1:0]  esz_q,  esz_n;
  logic        mix_q,  mix_n;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_v[g] = look_i[g].vld &&
      (((look_i[g].vtag ^ vaddr_i[31:12]) & tag_mask(look_i[g].sz)) == 20'd0);
  end

  // lowest slot wins: scan from the top so the lowest hit is written last
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (hit_v[k]) begin
        idx = IDX_W'(k);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    win   = look_i[idx];
    low_m = {~tag_mask(win.sz), 12'hFFF};
    pa    = ({win.ptag, 12'd0} & ~low_m) | (vaddr_i & low_m);
  end

  assign miss_o = req_i && xlat_en_i && !any;

  // next response; payload register enabled only on a request
  always_comb begin
    val_n  = req_i;
    hit_n  = hit_q;
    pa_n   = pa_q;
    endn_n = endn_q;
    esz_n  = esz_q;
    mix_n  = mix_q;
    if (req_i) begin
      if (!xlat_en_i) begin
        hit_n  = 1'b1;
        pa_n   = vaddr_i;
        endn_n = 1'b0;
        esz_n  = 2'd0;
        mix_n  = 1'b0;
      end else if (any) begin
        hit_n  = 1'b1;
        pa_n   = pa;
        endn_n = win.endn;
        esz_n  = win.esz;
        mix_n  = win.mix;
      end else begin
        hit_n  = 1'b0;
        pa_n   = '0;
        endn_n = 1'b0;
        esz_n  = 2'd0;
        mix_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= 1'b0;
      hit_q  <= 1'b0;
      pa_q   <= '0;
      endn_q <= 1'b0;
      esz_q  <= 2'd0;
      mix_q  <= 1'b0;
    end else begin
      val_q  <= val_n;
      hit_q  <= hit_n;
      pa_q   <= pa_n;
      endn_q <= endn_n;
      esz_q  <= esz_n;
      mix_q  <= mix_n;
    end
  end

  assign rsp_valid_o = val_q;
  assign rsp_hit_o   = hit_q;
  assign rsp_paddr_o = pa_q;
  assign rsp_endn_o  = endn_q;
  assign rsp_esz_o   = esz_q;
  assign rsp_mix_o   = mix_q;

  // R11
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !xlat_en_i) |=> (rsp_hit_o && (rsp_paddr_o == $past(vaddr_i))));

  // R9
  miss_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |=> (rsp_valid_o && !rsp_hit_o));

  // R4
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(req_i));

endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
  import sw_tlb_pkg::*;
#(
  parameter  int ENTRIES = 32,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lk_req,
  input  logic [31:0] lk_vaddr,
  output logic        lk_rsp_valid,
  output logic        lk_hit,
  output logic [31:0] lk_paddr,
  output logic        lk_endian,
  output logic [1:0]  lk_elem_sz,
  output logic        lk_mixed,
  output logic        irq
);

  logic                xlat_en;
  slot_t               stg;
  logic [IDX_W-1:0]    victim;
  logic                load, flush1, sweep;
  logic                miss;
  look_t [ENTRIES-1:0] look;

  sw_tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .miss_i      (miss),
    .miss_addr_i (lk_vaddr),
    .xlat_en_o   (xlat_en),
    .stg_o       (stg),
    .victim_o    (victim),
    .load_o      (load),
    .flush1_o    (flush1),
    .sweep_o     (sweep),
    .irq_o       (irq)
  );

  sw_tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .victim_i (victim),
    .stg_i    (stg),
    .flush1_i (flush1),
    .sweep_i  (sweep),
    .look_o   (look)
  );

  sw_tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (lk_req),
    .vaddr_i     (lk_vaddr),
    .xlat_en_i   (xlat_en),
    .look_i      (look),
    .miss_o      (miss),
    .rsp_valid_o (lk_rsp_valid),
    .rsp_hit_o   (lk_hit),
    .rsp_paddr_o (lk_paddr),
    .rsp_endn_o  (lk_endian),
    .rsp_esz_o   (lk_elem_sz),
    .rsp_mix_o   (lk_mixed)
  );

endmodule

// File: tb/sw_tlb_tb.sv
`timescale 1ns/1ps
module sw_tlb_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_rsp_valid, lk_hit, lk_endian, lk_mixed, irq;
  logic [31:0] lk_paddr;
  logic [1:0]  lk_elem_sz;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sw_tlb u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req),
    .lk_vaddr(lk_vaddr), .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit),
    .lk_paddr(lk_paddr), .lk_endian(lk_endian), .lk_elem_sz(lk_elem_sz),
    .lk_mixed(lk_mixed), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic look(input logic [31:0] va);
    lk_req = 1'b1; lk_vaddr = va;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  function automatic int shift_of(input int sz);
    case (sz)
      2: return 12;
      1: return 16;
      0: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [31:0] vbase(input int i);
    return 32'(i + 1) << 24;
  endfunction

  function automatic logic [31:0] pbase(input int i);
    return {8'(i + 8'h80), 12'(i * 37), 12'h000};
  endfunction

  task automatic expect_hit(input int i, input logic [31:0] va, input string tag);
    logic [31:0] lm, ep;
    lm = (32'd1 << shift_of(i % 4)) - 1;
    ep = (pbase(i) & ~lm) | (va & lm);
    look(va);
    chk(lk_rsp_valid && lk_hit, tag, {31'd0, lk_hit}, 32'd1);
    chk(lk_paddr == ep, tag, lk_paddr, ep);
    chk({lk_endian, lk_elem_sz, lk_mixed} == {i[0], i[2:1], i[3]},
        "R5", {28'd0, lk_endian, lk_elem_sz, lk_mixed}, {28'd0, i[0], i[2:1], i[3]});
  endtask

  initial begin
    logic [31:0] d, va, lm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, d); chk(d == 0, "R1", d, 0);
    rd(8'h04, d); chk(d == 0, "R1", d, 0);
    rd(8'h18, d); chk(d == 0, "R1", d, 0);
    rd(8'h20, d); chk(d == 0, "R1", d, 0);
    chk(!irq && !lk_rsp_valid, "R1", {30'd0, irq, lk_rsp_valid}, 0);
    wr(8'h00, 32'h1);
    look(32'h0100_0000);
    chk(lk_rsp_valid && !lk_hit, "R1", {31'd0, lk_hit}, 0);
    wr(8'h18, 32'h1);

    // R3 clamp, R2 wrap to base
    wr(8'h04, 32'h0000_0401);
    rd(8'h04, d); chk(d == 32'h0404, "R3", d, 32'h0404);
    wr(8'h04, 32'h0000_1E1F);
    wr(8'h10, 32'h1);
    rd(8'h04, d); chk(d == 32'h1E1E, "R2", d, 32'h1E1E);

    // R2 fill every slot
    wr(8'h04, 32'h0);
    for (int i = 0; i < 32; i++) begin
      wr(8'h08, vbase(i) | (32'(i >= 28) << 3) | 32'h4 | 32'(i % 4));
      wr(8'h0C, pbase(i) | (32'(i & 1) << 9) | (32'((i >> 1) & 3) << 7) |
                (32'((i >> 3) & 1) << 6));
      wr(8'h10, 32'h1);
    end
    rd(8'h04, d); chk(d == 32'h0, "R2", d, 0);

    // R4/R5 hits, R9/R10 misses
    wr(8'h1C, 32'h1);
    for (int i = 0; i < 32; i++) begin
      lm = (32'd1 << shift_of(i % 4)) - 1;
      expect_hit(i, vbase(i) | (32'h00FF_FFFF & lm), "R4");
      if (i % 4 != 3) begin
        va = vbase(i) | (32'd1 << shift_of(i % 4));
        look(va);
        chk(!lk_hit, "R9", {31'd0, lk_hit}, 0);
        rd(8'h20, d); chk(d == va, "R9", d, va);
        chk(irq, "R10", {31'd0, irq}, 1);
        wr(8'h18, 32'h1);
        chk(!irq, "R10", {31'd0, irq}, 0);
      end
    end

    // R6 lower slot wins
    wr(8'h04, 32'h5);
    wr(8'h08, vbase(31) | 32'h4 | 32'h3);
    wr(8'h0C, 32'hC300_0000);
    wr(8'h10, 32'h1);
    look(vbase(31) | 32'h0012_3456);
    chk(lk_hit && lk_paddr == 32'hC312_3456, "R6", lk_paddr, 32'hC312_3456);

    // R8 sweep
    wr(8'h60, 32'h0);
    for (int i = 0; i < 28; i++) begin
      look(vbase(i));
      chk(!lk_hit, "R8", {31'd0, lk_hit}, 0);
    end
    wr(8'h18, 32'h1);
    for (int i = 28; i < 32; i++) expect_hit(i, vbase(i), "R8");

    // R7 targeted flush: wrong size leaves slot 29, right size removes preserved slot 30
    wr(8'h08, vbase(29) | 32'h2);
    wr(8'h14, 32'h1);
    expect_hit(29, vbase(29), "R7");
    wr(8'h08, vbase(30) | 32'h2);
    wr(8'h14, 32'h1);
    look(vbase(30));
    chk(!lk_hit, "R7", {31'd0, lk_hit}, 0);

    // R10 masking and ack
    wr(8'h18, 32'h1);
    wr(8'h1C, 32'h0);
    look(32'h7700_0000);
    rd(8'h18, d); chk(d == 1 && !irq, "R10", {d[30:0], irq}, 32'h2);
    wr(8'h1C, 32'h1);
    chk(irq, "R10", {31'd0, irq}, 1);
    wr(8'h18, 32'h1);
    rd(8'h18, d); chk(d == 0, "R10", d, 0);

    // R11 translation off
    wr(8'h00, 32'h0);
    look(32'h1234_5678);
    chk(lk_hit && lk_paddr == 32'h1234_5678, "R11", lk_paddr, 32'h1234_5678);
    chk({lk_endian, lk_elem_sz, lk_mixed} == 0, "R11", {28'd0, lk_endian, lk_elem_sz, lk_mixed}, 0);
    rd(8'h18, d); chk(d == 0 && !irq, "R11", d, 0);

    // R12 table base
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, d); chk(d == 32'hFFFF_FF80, "R12", d, 32'hFFFF_FF80);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule